// File: doc/BRIEF.md
# Backlight PWM Generator

This block drives one backlight dimming pin from a reference clock. A configuration word selects the counter enable, the pin polarity, the period length, the on-time and the time granularity. The block counts reference ticks and holds the pin at its active level for the first part of each period and at its inactive level for the rest.

Two configuration modes exist. In the packed mode, one 32-bit word carries a 16-bit period count and a 16-bit on-time count. Both counts are in units of 16 or 128 reference ticks, picked by a select bit. In the unscaled mode, two separate 32-bit values give the period and the on-time directly in reference ticks. New settings take effect only when a period ends, so that no period is cut short. A one-cycle strobe marks the last tick of every period.

Top module: `bl_pwm_gen`

## Requirements
- R1: While `en_i` is 0, `pwm_out` sits at the inactive level, `period_end_o` stays 0, and the next enable starts a fresh period. This also holds in reset, where the inactive level is low.
- R2: With `pol_inv_i` = 0 the pin is high during the on-time and low otherwise. With `pol_inv_i` = 1 both levels are swapped, and the pin idles high while disabled.
- R3: In packed mode a period lasts `div` × M reference ticks and the on-time lasts `duty` × M ticks, where M is the granularity.
- R4: M is 16 when `gran_sel_i` = 0 and 128 when `gran_sel_i` = 1.
- R5: In packed mode `div` is taken from bits 31:16 of `packed_cfg_i` and `duty` from bits 15:0.
- R6: An on-time of 0 keeps the pin inactive for the whole period. An on-time equal to the period keeps it active for the whole period.
- R7: When `wide_mode_i` = 1, `wide_period_i` and `wide_duty_i` count reference ticks with no scaling, and `packed_cfg_i` and `gran_sel_i` have no effect.
- R8: An on-time larger than the period acts as an on-time equal to the period, giving 100% active time.
- R9: A change of period, on-time, mode, granularity or polarity while running takes effect only from the first tick after the current period ends.
- R10: A period of zero holds the pin at the inactive level and produces no period strobe.
- R11: `period_end_o` is 1 during exactly the last reference tick of each running period.
- R12: Each period, including the first one after enable, begins with its on-time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Counter enable; 0 forces the inactive level at once |
| pol_inv_i | input | 1 | 1 swaps the active and inactive pin levels |
| wide_mode_i | input | 1 | 1 selects unscaled 32-bit period and on-time |
| gran_sel_i | input | 1 | Packed-mode granularity: 0 for 16 ticks, 1 for 128 ticks |
| packed_cfg_i | input | 32 | Packed mode: period in 31:16, on-time in 15:0 |
| wide_period_i | input | 32 | Unscaled-mode period in reference ticks |
| wide_duty_i | input | 32 | Unscaled-mode on-time in reference ticks |
| pwm_out | output | 1 | Backlight PWM pin |
| period_end_o | output | 1 | Strobe on the last tick of each period |

## Verification
The bench compares the pin and the strobe on every cycle against a tick-level model of the requirements. The packed mode is driven with both granularities, so a wrong multiplier or swapped fields shift the edges by whole units. The unscaled mode runs with short periods and non-zero packed fields, which shows whether any scaling leaks in. On-times of zero, equal to the period and above it separate the clamp from plain comparison. A mid-period change of period and on-time, a period of zero, and a disable in mid-period followed by a re-enable test the boundary latching, the idle rule and the restart with the on-time first.

// File: rtl/bl_pwm_pkg.sv
package bl_pwm_pkg;

   // Default widths shared by the generator and its checker
   localparam int unsigned BL_HALF_W  = 16;
   localparam int unsigned BL_WIDE_W  = 32;
   localparam int unsigned BL_GRAN_LO = 16;
   localparam int unsigned BL_GRAN_HI = 128;

   typedef enum logic {
      BL_MODE_PACKED = 1'b0,
      BL_MODE_WIDE   = 1'b1
   } bl_mode_e;

endpackage

// File: rtl/bl_pwm_decode.sv
// Turns the live configuration into a period count, a clamped on-time
// threshold and a prescaler limit.
module bl_pwm_decode #(
   parameter int unsigned HALF_W       = 16,
   parameter int unsigned CNT_W        = 32,
   parameter int unsigned PRE_W        = 7,
   parameter int unsigned GRAN_LO      = 16,
   parameter int unsigned GRAN_HI      = 128,
   parameter bit          SUPPORT_WIDE = 1'b1
) (
   input  logic                wide_mode_i,
   input  logic                gran_sel_i,
   input  logic [2*HALF_W-1:0] packed_cfg_i,
   input  logic [CNT_W-1:0]    wide_period_i,
   input  logic [CNT_W-1:0]    wide_duty_i,
   output logic [CNT_W-1:0]    per_o,
   output logic [CNT_W-1:0]    thr_o,
   output logic [PRE_W-1:0]    pmax_o
);
   import bl_pwm_pkg::*;

   localparam logic [PRE_W-1:0] PMAX_LO = PRE_W'(GRAN_LO - 1);
   localparam logic [PRE_W-1:0] PMAX_HI = PRE_W'(GRAN_HI - 1);

   logic [CNT_W-1:0] pk_per, pk_duty;
   logic [PRE_W-1:0] pk_pmax;
   logic [CNT_W-1:0] sel_duty;

   assign pk_per  = CNT_W'(packed_cfg_i[2*HALF_W-1:HALF_W]);
   assign pk_duty = CNT_W'(packed_cfg_i[HALF_W-1:0]);
   assign pk_pmax = gran_sel_i ? PMAX_HI : PMAX_LO;

   generate
      if (SUPPORT_WIDE) begin : g_two_modes
         bl_mode_e mode;
         assign mode = bl_mode_e'(wide_mode_i);
         always_comb begin
            if (mode == BL_MODE_WIDE) begin
               per_o    = wide_period_i;
               sel_duty = wide_duty_i;
               pmax_o   = '0;
            end else begin
               per_o    = pk_per;
               sel_duty = pk_duty;
               pmax_o   = pk_pmax;
            end
         end
      end else begin : g_packed_only
         logic unused_wide;
         assign unused_wide = wide_mode_i ^ (^wide_period_i) ^ (^wide_duty_i);
         assign per_o    = pk_per;
         assign sel_duty = pk_duty;
         assign pmax_o   = pk_pmax;
      end
   endgenerate

   // On-time above the period saturates at the full period
   assign thr_o = (sel_duty > per_o) ? per_o : sel_duty;

endmodule

// File: rtl/bl_pwm_shadow.sv
// Holds the settings in effect for the running period.
module bl_pwm_shadow #(
   parameter int unsigned CNT_W = 32,
   parameter int unsigned PRE_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [CNT_W-1:0] per_i,
   input  logic [CNT_W-1:0] thr_i,
   input  logic [PRE_W-1:0] pmax_i,
   input  logic             pol_i,
   output logic [CNT_W-1:0] per_o,
   output logic [CNT_W-1:0] thr_o,
   output logic [PRE_W-1:0] pmax_o,
   output logic             pol_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         per_o  <= '0;
         thr_o  <= '0;
         pmax_o <= '0;
         pol_o  <= 1'b0;
      end else if (load_i) begin
         per_o  <= per_i;
         thr_o  <= thr_i;
         pmax_o <= pmax_i;
         pol_o  <= pol_i;
      end
   end

endmodule

// File: rtl/bl_pwm_count.sv
// Two-stage counter: a granularity prescaler feeding a unit counter.
module bl_pwm_count #(
   parameter int unsigned CNT_W = 32,
   parameter int unsigned PRE_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear_i,
   input  logic [CNT_W-1:0] per_i,
   input  logic [PRE_W-1:0] pmax_i,
   output logic [CNT_W-1:0] unit_o,
   output logic [PRE_W-1:0] pre_o,
   output logic             last_o
);

   logic pre_wrap;

   assign pre_wrap = (pre_o == pmax_i);
   assign last_o   = pre_wrap && (unit_o == (per_i - CNT_W'(1)));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pre_o  <= '0;
         unit_o <= '0;
      end else if (clear_i || last_o) begin
         pre_o  <= '0;
         unit_o <= '0;
      end else if (pre_wrap) begin
         pre_o  <= '0;
         unit_o <= unit_o + CNT_W'(1);
      end else begin
         pre_o  <= pre_o + PRE_W'(1);
      end
   end

endmodule

// File: rtl/bl_pwm_gen.sv
module bl_pwm_gen #(
   parameter int unsigned HALF_W       = bl_pwm_pkg::BL_HALF_W,
   parameter int unsigned CNT_W        = bl_pwm_pkg::BL_WIDE_W,
   parameter int unsigned GRAN_LO      = bl_pwm_pkg::BL_GRAN_LO,
   parameter int unsigned GRAN_HI      = bl_pwm_pkg::BL_GRAN_HI,
   parameter bit          SUPPORT_WIDE = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                en_i,
   input  logic                pol_inv_i,
   input  logic                wide_mode_i,
   input  logic                gran_sel_i,
   input  logic [2*HALF_W-1:0] packed_cfg_i,
   input  logic [CNT_W-1:0]    wide_period_i,
   input  logic [CNT_W-1:0]    wide_duty_i,
   output logic                pwm_out,
   output logic                period_end_o
);

   localparam int unsigned PRE_W = (GRAN_HI > 1) ? $clog2(GRAN_HI) : 1;

   generate
      if (GRAN_HI <= GRAN_LO) begin : g_bad_gran
         $error("GRAN_HI must exceed GRAN_LO");
      end
      if (CNT_W < HALF_W) begin : g_bad_width
         $error("CNT_W must hold a packed field");
      end
      if (GRAN_LO < 1) begin : g_bad_lo
         $error("GRAN_LO must be at least 1");
      end
   endgenerate

   logic [CNT_W-1:0] live_per, live_thr;
   logic [PRE_W-1:0] live_pmax;
   logic [CNT_W-1:0] sh_per, sh_thr, unit_q;
   logic [PRE_W-1:0] sh_pmax, pre_q;
   logic             sh_pol, last_tick, idle, load;

   bl_pwm_decode #(
      .HALF_W(HALF_W), .CNT_W(CNT_W), .PRE_W(PRE_W),
      .GRAN_LO(GRAN_LO), .GRAN_HI(GRAN_HI), .SUPPORT_WIDE(SUPPORT_WIDE)
   ) u_decode (
      .wide_mode_i  (wide_mode_i),
      .gran_sel_i   (gran_sel_i),
      .packed_cfg_i (packed_cfg_i),
      .wide_period_i(wide_period_i),
      .wide_duty_i  (wide_duty_i),
      .per_o        (live_per),
      .thr_o        (live_thr),
      .pmax_o       (live_pmax)
   );

   // Idle while disabled or while the period in effect is zero
   assign idle = !en_i || (sh_per == '0);
   assign load = idle || last_tick;

   bl_pwm_shadow #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_shadow (
      .clk   (clk),
      .rst_n (rst_n),
      .load_i(load),
      .per_i (live_per),
      .thr_i (live_thr),
      .pmax_i(live_pmax),
      .pol_i (pol_inv_i),
      .per_o (sh_per),
      .thr_o (sh_thr),
      .pmax_o(sh_pmax),
      .pol_o (sh_pol)
   );

   bl_pwm_count #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_count (
      .clk    (clk),
      .rst_n  (rst_n),
      .clear_i(idle),
      .per_i  (sh_per),
      .pmax_i (sh_pmax),
      .unit_o (unit_q),
      .pre_o  (pre_q),
      .last_o (last_tick)
   );

   assign pwm_out      = (!idle && (unit_q < sh_thr)) ^ sh_pol;
   assign period_end_o = !idle && last_tick;

endmodule

// File: rtl/bl_pwm_gen_chk.sv
module bl_pwm_gen_chk #(
   parameter int unsigned CNT_W = 32,
   parameter int unsigned PRE_W = 7
) (
   input logic             clk,
   input logic             rst_n,
   input logic             en_i,
   input logic             period_end_o,
   input logic [CNT_W-1:0] sh_per,
   input logic [CNT_W-1:0] sh_thr,
   input logic [PRE_W-1:0] sh_pmax,
   input logic             sh_pol,
   input logic [CNT_W-1:0] unit_q,
   input logic [PRE_W-1:0] pre_q
);

   // R1
   no_strobe_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en_i |-> !period_end_o);

   // R9
   shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en_i && sh_per != '0 && !period_end_o) |=>
         ($stable(sh_per) && $stable(sh_thr) && $stable(sh_pmax) && $stable(sh_pol)));

   // R11
   restart_after_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      period_end_o |=> (unit_q == '0 && pre_q == '0));

   // R3
   unit_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en_i && sh_per != '0) |-> (unit_q < sh_per));

   // R4
   pre_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en_i && sh_per != '0) |-> (pre_q <= sh_pmax));

   // R8
   thr_clamped_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sh_thr <= sh_per);

endmodule

bind bl_pwm_gen bl_pwm_gen_chk #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .en_i        (en_i),
   .period_end_o(period_end_o),
   .sh_per      (sh_per),
   .sh_thr      (sh_thr),
   .sh_pmax     (sh_pmax),
   .sh_pol      (sh_pol),
   .unit_q      (unit_q),
   .pre_q       (pre_q)
);

// File: tb/bl_pwm_gen_bench.sv
`timescale 1ns/100ps
module bl_pwm_gen_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        en_i = 1'b0;
   logic        pol_inv_i = 1'b0;
   logic        wide_mode_i = 1'b0;
   logic        gran_sel_i = 1'b0;
   logic [31:0] packed_cfg_i = '0;
   logic [31:0] wide_period_i = '0;
   logic [31:0] wide_duty_i = '0;
   logic        pwm_out, period_end_o;

   always #2.5 clk = ~clk;

   bl_pwm_gen u_bl_pwm_gen (
      .clk(clk), .rst_n(rst_n), .en_i(en_i), .pol_inv_i(pol_inv_i),
      .wide_mode_i(wide_mode_i), .gran_sel_i(gran_sel_i),
      .packed_cfg_i(packed_cfg_i), .wide_period_i(wide_period_i),
      .wide_duty_i(wide_duty_i), .pwm_out(pwm_out), .period_end_o(period_end_o)
   );

   typedef struct {
      bit    out;
      bit    fin;
      string tag;
   } exp_t;

   exp_t q[$];
   int   checks = 0;
   int   errors = 0;
   bit   done   = 1'b0;

   // Drive values, applied at the next falling edge
   bit          d_rst_n = 1'b0, d_en = 1'b0, d_pol = 1'b0, d_wide = 1'b0, d_gran = 1'b0;
   logic [31:0] d_packed = '0, d_wper = '0, d_wduty = '0;

   // Requirement model: settings in effect and the tick position
   int unsigned m_per = 0, m_thr = 0, m_pmax = 0, m_pre = 0, m_unit = 0;
   bit          m_pol = 1'b0;

   task automatic live_cfg(output int unsigned p, output int unsigned t,
                           output int unsigned pm);
      int unsigned d;
      if (d_wide) begin
         p = d_wper; d = d_wduty; pm = 0;                 // R7
      end else begin
         p = d_packed[31:16]; d = d_packed[15:0];         // R5
         pm = d_gran ? 127 : 15;                          // R4
      end
      t = (d > p) ? p : d;                                // R8
   endtask

   task automatic cyc(input string tag);
      exp_t e;
      bit   run;
      int unsigned lp, lt, lpm;
      @(negedge clk);
      rst_n = d_rst_n; en_i = d_en; pol_inv_i = d_pol; wide_mode_i = d_wide;
      gran_sel_i = d_gran; packed_cfg_i = d_packed;
      wide_period_i = d_wper; wide_duty_i = d_wduty;
      run   = d_en && (m_per != 0);
      e.out = (run && (m_unit < m_thr)) ^ m_pol;
      e.fin = run && (m_pre == m_pmax) && (m_unit == m_per - 1);
      e.tag = tag;
      q.push_back(e);
      if (d_rst_n) begin
         if (!run || e.fin) begin
            live_cfg(lp, lt, lpm);
            m_per = lp; m_thr = lt; m_pmax = lpm; m_pol = d_pol;
            m_pre = 0; m_unit = 0;
         end else if (m_pre == m_pmax) begin
            m_pre = 0; m_unit++;
         end else begin
            m_pre++;
         end
      end
   endtask

   task automatic run_n(input int n, input string tag);
      for (int i = 0; i < n; i++) cyc(tag);
   endtask

   // Monitor: pops one expected item per cycle, away from the rising edge
   initial begin
      exp_t e;
      forever begin
         @(negedge clk);
         #1;
         if (q.size() > 0) begin
            e = q.pop_front();
            checks++;
            if (pwm_out !== e.out || period_end_o !== e.fin) begin
               errors++;
               $display("FAIL %s: pwm/end actual %b/%b expected %b/%b at %0t",
                        e.tag, pwm_out, period_end_o, e.out, e.fin, $time);
            end
         end
      end
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual hung expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      // Reset state: inactive low, no strobe (R1)
      run_n(3, "R1 reset");
      d_rst_n = 1'b1;
      run_n(2, "R1");

      // Packed, granularity 16: period 4 units, on-time 1 unit
      d_packed = {16'd4, 16'd1};
      run_n(2, "R5");
      d_en = 1'b1;
      run_n(130, "R3 R5 R11 R12");

      // Packed, granularity 128: period 2 units, on-time 1 unit
      d_en = 1'b0; d_gran = 1'b1; d_packed = {16'd2, 16'd1};
      run_n(2, "R4");
      d_en = 1'b1;
      run_n(300, "R4 R3");

      // Unscaled: packed fields must not matter
      d_en = 1'b0; d_wide = 1'b1; d_wper = 32'd10; d_wduty = 32'd3;
      d_packed = {16'd7, 16'd7}; d_gran = 1'b0;
      run_n(2, "R7");
      d_en = 1'b1;
      run_n(35, "R7");

      // Inverted polarity, idle and running
      d_en = 1'b0; d_pol = 1'b1;
      run_n(3, "R1 R2");
      d_en = 1'b1;
      run_n(25, "R2");
      d_en = 1'b0; d_pol = 1'b0;
      run_n(2, "R2");

      // On-time extremes and clamp
      d_wduty = 32'd0; d_en = 1'b1;
      run_n(25, "R6 zero");
      d_en = 1'b0; run_n(2, "R6");
      d_wduty = 32'd10; d_en = 1'b1;
      run_n(25, "R6 full");
      d_en = 1'b0; run_n(2, "R8");
      d_wduty = 32'd50; d_en = 1'b1;
      run_n(25, "R8 wide");
      d_en = 1'b0; d_wide = 1'b0; d_packed = {16'd2, 16'd9};
      run_n(2, "R8");
      d_en = 1'b1;
      run_n(70, "R8 packed");

      // Mid-period change waits for the boundary
      d_en = 1'b0; d_wide = 1'b1; d_wper = 32'd8; d_wduty = 32'd2;
      run_n(2, "R9");
      d_en = 1'b1;
      run_n(13, "R9");
      d_wper = 32'd12; d_wduty = 32'd6; d_pol = 1'b1;
      run_n(40, "R9");
      d_pol = 1'b0;

      // Period of zero taken at the boundary, then idle
      d_wper = 32'd0; d_wduty = 32'd3;
      run_n(40, "R10");

      // Disable mid-period, re-enable restarts with on-time
      d_en = 1'b0; d_wper = 32'd10; d_wduty = 32'd8;
      run_n(2, "R1");
      d_en = 1'b1;
      run_n(4, "R12");
      d_en = 1'b0;
      run_n(5, "R1 disable");
      d_en = 1'b1;
      run_n(15, "R12 restart");

      @(negedge clk);
      #2;
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule